// File: doc/BRIEF.md
# Idle-Driven Memory Power-Mode Controller

This block keeps track of the power level of a single memory module. The module has four levels. From highest to lowest power they are active, standby, nap and power-down. While no request arrives, an idle counter runs. Each time the counter reaches a programmable limit, the module drops to a lower level. A request seen while the module is below active starts a wake-up. The wake-up lasts a fixed number of cycles, and that number depends on the level being left. During the wake-up the request is held off with a stall flag. Once the module is back in active, the request is granted.

An entry selector chooses how an idle module descends. It can step down the whole ladder one level at a time. It can also jump once, straight to nap or straight to standby, and then stay at that level. The surrounding memory controller drives the request handshake. It reads the current level to decide when the array may be accessed.

Top module: `mem_pwr_ladder`

## Requirements
- R1: During and right after reset the level output reads active (code 0), ready is high and neither grant nor stall is asserted while no request is present.
- R2: Level codes are 0 active, 1 standby, 2 nap, 3 power-down. A request presented while the level is active is granted in the same cycle, with ready high and stall low.
- R3: With entry select 0 (or 3), after `idle_limit` consecutive cycles without a request the level drops by one. The new level is visible from the cycle after the last idle cycle.
- R4: The idle count restarts from zero after every request cycle and after every level change, so a request before the limit is reached prevents any descent.
- R5: Once in power-down, the level stays at 3 for as long as no request arrives.
- R6: A request first presented in cycle k while the level is standby, nap or power-down is answered with ready in cycle k+2, k+8 or k+32 respectively (parameters). The level switches to active in that same cycle.
- R7: While a wake-up is in progress, ready is low, stall equals the request input, and no further descent happens, even if the request is withdrawn. The wake-up still completes to active.
- R8: Entry select 1 sends an idle active module straight to nap, and entry select 2 sends it straight to standby. The module then stays at that level until a request arrives.
- R9: An `idle_limit` of 0 disables descent. Limits of 100 and 1000 are honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read or write request pending |
| req_ready | output | 1 | Module is active and can take the request |
| idle_limit | input | CNT_W (16) | Idle cycles per step down; 0 disables descent |
| entry_sel | input | 2 | 0/3 ladder, 1 direct to nap, 2 direct to standby |
| mode_o | output | 2 | Current power level code |
| grant_o | output | 1 | Request accepted this cycle |
| stall_o | output | 1 | Request held off by a wake-up |

## Verification
Grant, ready and stall are combinational functions of the registered level and the request input. They are therefore due in the same cycle as the stimulus. A level drop appears one cycle after the limit-th idle cycle. Active returns exactly 2, 8 or 32 cycles after the request first appears.

The bench drives inputs on the falling edge. A reference model advances one step per driven cycle and queues the outputs expected for that cycle. A monitor compares them a quarter period later, before the next rising edge. In this way every expectation lines up with the cycle it belongs to.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_STANDBY = 2'd1,
    PM_NAP     = 2'd2,
    PM_PDOWN   = 2'd3
  } pm_e;

  typedef enum logic [1:0] {
    ENT_LADDER  = 2'd0,
    ENT_NAP     = 2'd1,
    ENT_STBY    = 2'd2,
    ENT_LADDER2 = 2'd3
  } entry_e;

  // Level reached after an idle expiry from the given level.
  function automatic pm_e lower_of(input pm_e cur, input entry_e sel);
    pm_e nxt;
    nxt = cur;
    if (cur == PM_ACTIVE) begin
      case (sel)
        ENT_NAP:  nxt = PM_NAP;
        ENT_STBY: nxt = PM_STANDBY;
        default:  nxt = PM_STANDBY;
      endcase
    end else if (cur == PM_STANDBY) begin
      nxt = PM_NAP;
    end else begin
      nxt = PM_PDOWN;
    end
    return nxt;
  endfunction
endpackage

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] next_cnt;

  assign next_cnt = {1'b0, cnt_q} + EXT_W'(1);
  assign hit = en && (limit != '0) && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !en || hit) cnt_q <= '0;
    else                   cnt_q <= next_cnt[CNT_W-1:0];
  end

  // Counting restarts after any non-counting cycle
  assert_idle_restart_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == '0);
  // A zero limit never fires
  assert_zero_limit_R9: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |-> !hit);
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             done
);
  logic [LAT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == LAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= lat - LAT_W'(1);
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q - LAT_W'(1);
    end
  end

  assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q != '0);
endmodule

// File: rtl/mem_pwr_ladder.sv
module mem_pwr_ladder
  import pwr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LAT_STBY = 2,
  parameter int LAT_NAP  = 8,
  parameter int LAT_PDN  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic [1:0]       entry_sel,
  output logic [1:0]       mode_o,
  output logic             grant_o,
  output logic             stall_o
);
  localparam int LAT_MAX0 = (LAT_STBY > LAT_NAP) ? LAT_STBY : LAT_NAP;
  localparam int LAT_MAX  = (LAT_MAX0 > LAT_PDN) ? LAT_MAX0 : LAT_PDN;
  localparam int LAT_W    = $clog2(LAT_MAX + 1);

  initial begin
    if (LAT_STBY < 2 || LAT_NAP < 2 || LAT_PDN < 2)
      $error("wake latencies must be at least 2");
  end

  pm_e              mode_q;
  entry_e           sel;
  logic             idle_en, idle_hit;
  logic             wake_start, wake_busy, wake_done;
  logic [LAT_W-1:0] wake_lat;
  logic             may_descend;

  assign sel = entry_e'(entry_sel);

  always_comb begin
    case (mode_q)
      PM_STANDBY: wake_lat = LAT_W'(LAT_STBY);
      PM_NAP:     wake_lat = LAT_W'(LAT_NAP);
      default:    wake_lat = LAT_W'(LAT_PDN);
    endcase
  end

  always_comb begin
    if (mode_q == PM_ACTIVE)     may_descend = 1'b1;
    else if (mode_q == PM_PDOWN) may_descend = 1'b0;
    else                         may_descend = (sel == ENT_LADDER) || (sel == ENT_LADDER2);
  end

  assign idle_en    = !req_valid && !wake_busy && may_descend;
  assign wake_start = req_valid && (mode_q != PM_ACTIVE) && !wake_busy;

  pwr_idle_timer #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst(rst), .en(idle_en), .limit(idle_limit), .hit(idle_hit)
  );

  pwr_wake_timer #(.LAT_W(LAT_W)) u_wake (
    .clk(clk), .rst(rst), .start(wake_start), .lat(wake_lat),
    .busy(wake_busy), .done(wake_done)
  );

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= PM_ACTIVE;
    else if (wake_done) mode_q <= PM_ACTIVE;
    else if (idle_hit) mode_q <= lower_of(mode_q, sel);
  end

  assign mode_o    = mode_q;
  assign req_ready = (mode_q == PM_ACTIVE);
  assign grant_o   = req_valid && req_ready;
  assign stall_o   = req_valid && !req_ready;

  assert_grant_in_active_R2: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> (mode_o == 2'd0) && !stall_o);
  assert_no_drop_on_request_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !(mode_o > $past(mode_o)));
  assert_pdown_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) && !req_valid && !wake_busy |=> mode_o == 2'd3);
  assert_wake_needed_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0) && !wake_busy |=> mode_o != 2'd0);
  assert_wake_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    wake_busy |-> !req_ready);
  assert_direct_nap_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) && (entry_sel == 2'd1) && !req_valid && !wake_busy |=> mode_o == 2'd2);
endmodule

// File: tb/sim_mem_pwr_ladder.sv
module sim_mem_pwr_ladder;
  typedef struct {
    logic [1:0] mode;
    logic       ready;
    logic       grant;
    logic       stall;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] idle_limit = 16'd4;
  logic [1:0]  entry_sel = 2'd0;
  logic        req_ready, grant_o, stall_o;
  logic [1:0]  mode_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // model state
  int m = 0;
  int idle = 0;
  int wl = 0;

  always #10 clk = ~clk;

  mem_pwr_ladder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .idle_limit(idle_limit), .entry_sel(entry_sel), .mode_o(mode_o),
    .grant_o(grant_o), .stall_o(stall_o)
  );

  function automatic int lat_of(input int lvl);
    return (lvl == 1) ? 2 : (lvl == 2) ? 8 : 32;
  endfunction

  task automatic step(input logic v, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v;
    e.mode  = 2'(m);
    e.ready = (m == 0);
    e.grant = v && (m == 0);
    e.stall = v && (m != 0);
    e.tag   = tag;
    q.push_back(e);
    if (wl != 0) begin
      wl--;
      if (wl == 0) begin m = 0; idle = 0; end
    end else if (m == 0) begin
      if (v) idle = 0;
      else if (idle_limit != 0 && idle + 1 >= int'(idle_limit)) begin
        m = (entry_sel == 2'd1) ? 2 : 1;
        idle = 0;
      end else idle++;
    end else if (v) begin
      wl = lat_of(m) - 1;
      idle = 0;
    end else if ((entry_sel == 2'd0 || entry_sel == 2'd3) && m != 3) begin
      if (idle_limit != 0 && idle + 1 >= int'(idle_limit)) begin m++; idle = 0; end
      else idle++;
    end else idle = 0;
  endtask

  task automatic idle_for(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic wake(input string tag);
    while (m != 0) step(1'b1, tag);
    step(1'b1, tag);
    step(1'b0, tag);
  endtask

  // monitor: compare a quarter period after inputs change
  always @(negedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mode_o !== e.mode || req_ready !== e.ready || grant_o !== e.grant || stall_o !== e.stall) begin
        errors++;
        $display("FAIL %s: got mode=%0d rdy=%0b gnt=%0b stl=%0b expected mode=%0d rdy=%0b gnt=%0b stl=%0b",
                 e.tag, mode_o, req_ready, grant_o, stall_o, e.mode, e.ready, e.grant, e.stall);
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs under reset
    #5;
    checks++;
    if (mode_o !== 2'd0 || grant_o !== 1'b0 || stall_o !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: got mode=%0d gnt=%0b stl=%0b expected mode=0 gnt=0 stl=0", mode_o, grant_o, stall_o);
    end
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, "R1");
    // R2: back-to-back requests in active
    for (int i = 0; i < 3; i++) step(1'b1, "R2");
    // R4: requests before limit prevent descent
    idle_for(3, "R4"); step(1'b1, "R4"); idle_for(3, "R4"); step(1'b1, "R4");
    // R3: full ladder, limit 4
    idle_for(12, "R3");
    // R5: power-down holds
    idle_for(20, "R5");
    // R6: wake latency from each level
    wake("R6");
    idle_for(4, "R6"); wake("R6");
    idle_for(8, "R6"); wake("R6");
    // R7: withdrawn request still completes wake, no descent meanwhile
    idle_for(8, "R7"); step(1'b1, "R7"); idle_for(12, "R7");
    // R8: direct entries
    entry_sel = 2'd1; idle_for(12, "R8"); wake("R8");
    entry_sel = 2'd2; idle_for(12, "R8"); wake("R8");
    entry_sel = 2'd3; idle_for(9, "R8"); wake("R8");
    // R9: zero limit, then 100 and 1000
    entry_sel = 2'd0; idle_limit = 16'd0; idle_for(50, "R9");
    idle_limit = 16'd100; idle_for(310, "R9"); wake("R9");
    idle_limit = 16'd1000; idle_for(3010, "R9"); wake("R9");
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    #8;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule